// File: doc/BRIEF.md
# Idle-driven pipeline clock gate

This block sits beside a small four-stage pipelined core (fetch, decode, execute, memory/write-back) and decides when the clock to the pipeline register banks can stop. It watches three things on every edge of the free-running clock: the decoded opcode with its valid flag, the program counter, and an external wake request. When the core executes a halt, runs a stream of NOPs, or stops advancing its program counter, the block stops the clock to the register banks. It raises a sleep flag until a wake request or reset brings the clock back.

The decision logic always runs on the ungated clock, so it still sees the wake request while the pipeline is frozen. The gated clock comes from a latch that is open while the clock is low and an AND gate, so every delivered pulse is a full high phase of the source clock. Once the sleep state is entered it holds until it is cleared, because a frozen pipeline presents the same inputs on every cycle. Wake takes priority over every idle cause that is sampled on the same edge.

Top module: `idle_clk_gate`

## Requirements
- R1: While reset (rst_ni low, asynchronous) is asserted, sleep_o is 0 and every clk_i pulse appears on gclk_o. Reset also clears the NOP run count and the stored program counter history.
- R2: A valid opcode equal to HALT_OP (default 6'h3F) sampled on a clk_i rising edge sets sleep_o after that edge. gclk_o then gives no pulse from the next edge onward. A HALT_OP with op_valid_i low has no effect.
- R3: RUN_LEN (default 4) back-to-back valid opcodes equal to NOP_OP (default 6'h00) set sleep_o after the edge that follows the last of them. Any valid non-NOP opcode clears the run, so a shorter run never sets sleep_o.
- R4: Cycles with op_valid_i low neither add to nor clear the NOP run.
- R5: If pc_i holds the same value on HOLD_LEN+1 consecutive sampled edges (default three, that is two repeats), sleep_o is set one edge later. A single repeat followed by a change never sets it.
- R6: wake_i high on an edge clears sleep_o after that edge and restarts the NOP and PC detectors. gclk_o pulses again from the next edge.
- R7: When wake_i and any idle cause are sampled on the same edge, wake wins and sleep_o stays 0 after that edge.
- R8: Once set, sleep_o stays high until wake_i or reset, whatever the opcode and pc inputs do.
- R9: gclk_o is high only while clk_i is high, and each pulse covers a whole clk_i high phase.
- R10: While sleep_o is high, gclk_o has no pulse. While it is low, every clk_i pulse passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | free-running global clock |
| rst_ni | input | 1 | asynchronous active-low reset |
| op_valid_i | input | 1 | opcode_i holds a decoded instruction this cycle |
| opcode_i | input | OP_W | decoded opcode |
| pc_i | input | PC_W | current program counter |
| wake_i | input | 1 | request to leave the sleep state |
| gclk_o | output | 1 | gated clock for the pipeline register banks |
| sleep_o | output | 1 | high while the gated clock is stopped |

## Verification
The wake path and the idle detectors can act on the same edge. This happens when a halt, a finished NOP run or a stalled PC is on the inputs in the cycle wake_i is raised. The bench provokes it by presenting a valid halt together with wake_i while the block is awake. It expects sleep_o to stay low after that edge and to rise only on the following edge, once wake_i has dropped. The bench also counts gclk_o pulses around every sleep entry and exit, to show that the last pulse before sleep and the first pulse after wake fall on the expected edges.

// File: rtl/idle_clk_gate_pkg.sv
package idle_clk_gate_pkg;
    typedef struct packed {
        logic halt;
        logic nop_run;
        logic pc_stall;
    } idle_cause_t;
endpackage

// File: rtl/icg_nop_run.sv
module icg_nop_run #(
    parameter int          OP_W    = 6,
    parameter logic [OP_W-1:0] NOP_OP = '0,
    parameter int          RUN_LEN = 4
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            clr_i,
    input  logic            valid_i,
    input  logic [OP_W-1:0] opcode_i,
    output logic            run_o
);
    localparam int CNT_W = $clog2(RUN_LEN + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } nop_state_t;

    nop_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (valid_i) begin
            if (opcode_i == NOP_OP) begin
                if (st_q.cnt != CNT_W'(RUN_LEN)) st_d.cnt = st_q.cnt + 1'b1;
            end else begin
                st_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign run_o = (st_q.cnt == CNT_W'(RUN_LEN));
endmodule

// File: rtl/icg_pc_stall.sv
module icg_pc_stall #(
    parameter int PC_W     = 16,
    parameter int HOLD_LEN = 2
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            clr_i,
    input  logic [PC_W-1:0] pc_i,
    output logic            stall_o
);
    localparam int HW = $clog2(HOLD_LEN + 1);

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic            seen;
        logic [HW-1:0]   hold;
    } pc_state_t;

    pc_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pc   = pc_i;
        st_d.seen = 1'b1;
        if (clr_i) begin
            st_d.hold = '0;
        end else if (st_q.seen && (pc_i == st_q.pc)) begin
            if (st_q.hold != HW'(HOLD_LEN)) st_d.hold = st_q.hold + 1'b1;
        end else begin
            st_d.hold = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign stall_o = (st_q.hold == HW'(HOLD_LEN));
endmodule

// File: rtl/icg_latch_and.sv
module icg_latch_and (
    input  logic clk_i,
    input  logic en_i,
    output logic gclk_o
);
    logic en_lat;

    // open while the source clock is low, closed through the high phase
    always_latch begin
        if (!clk_i) en_lat = en_i;
    end

    assign gclk_o = clk_i & en_lat;
endmodule

// File: rtl/idle_clk_gate.sv
module idle_clk_gate
    import idle_clk_gate_pkg::*;
#(
    parameter int              OP_W     = 6,
    parameter int              PC_W     = 16,
    parameter logic [OP_W-1:0] NOP_OP   = '0,
    parameter logic [OP_W-1:0] HALT_OP  = '1,
    parameter int              RUN_LEN  = 4,
    parameter int              HOLD_LEN = 2
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            op_valid_i,
    input  logic [OP_W-1:0] opcode_i,
    input  logic [PC_W-1:0] pc_i,
    input  logic            wake_i,
    output logic            gclk_o,
    output logic            sleep_o
);
    typedef struct packed {
        logic sleep;
    } gate_state_t;

    gate_state_t st_d, st_q;
    idle_cause_t cause;

    icg_nop_run #(
        .OP_W(OP_W), .NOP_OP(NOP_OP), .RUN_LEN(RUN_LEN)
    ) u_nop (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (wake_i),
        .valid_i (op_valid_i),
        .opcode_i(opcode_i),
        .run_o   (cause.nop_run)
    );

    icg_pc_stall #(
        .PC_W(PC_W), .HOLD_LEN(HOLD_LEN)
    ) u_pc (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (wake_i),
        .pc_i   (pc_i),
        .stall_o(cause.pc_stall)
    );

    assign cause.halt = op_valid_i && (opcode_i == HALT_OP);

    always_comb begin
        st_d = st_q;
        if (wake_i)          st_d.sleep = 1'b0;
        else if (|cause)     st_d.sleep = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    icg_latch_and u_gate (
        .clk_i (clk_i),
        .en_i  (!st_q.sleep),
        .gclk_o(gclk_o)
    );

    assign sleep_o = st_q.sleep;
endmodule

// File: rtl/idle_clk_gate_chk.sv
module idle_clk_gate_chk #(
    parameter int              OP_W    = 6,
    parameter logic [OP_W-1:0] HALT_OP = '1
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            op_valid_i,
    input logic [OP_W-1:0] opcode_i,
    input logic            wake_i,
    input logic            gclk_o,
    input logic            sleep_o
);
    p_halt_sleeps_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_valid_i && opcode_i == HALT_OP && !wake_i) |=> sleep_o);

    p_wake_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_i |=> !sleep_o);

    p_sleep_holds_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sleep_o && !wake_i) |=> sleep_o);

    always @(posedge gclk_o) begin
        p_gclk_in_high_r9: assert (clk_i);
    end
endmodule

bind idle_clk_gate idle_clk_gate_chk #(.OP_W(OP_W), .HALT_OP(HALT_OP)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_valid_i(op_valid_i),
    .opcode_i  (opcode_i),
    .wake_i    (wake_i),
    .gclk_o    (gclk_o),
    .sleep_o   (sleep_o)
);

// File: tb/test_idle_clk_gate.sv
`timescale 1ns/1ps
module test_idle_clk_gate;
    localparam logic [5:0] NOP  = 6'h00;
    localparam logic [5:0] HALT = 6'h3F;
    localparam logic [5:0] ADD  = 6'h05;

    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic        vld = 1'b0;
    logic [5:0]  op = ADD;
    logic [15:0] pc = '0;
    logic        wake = 1'b0;
    logic        gclk, sleep;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;
    always @(posedge gclk) pulses++;

    idle_clk_gate i_idle_clk_gate (
        .clk_i(clk), .rst_ni(rst_n), .op_valid_i(vld), .opcode_i(op),
        .pc_i(pc), .wake_i(wake), .gclk_o(gclk), .sleep_o(sleep)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // drive at a falling edge, pass one rising edge, return at next falling edge
    task automatic tick(input logic v, input logic [5:0] o, input logic hold, input logic w);
        vld = v; op = o; wake = w;
        if (!hold) pc = pc + 16'd4;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic t_reset;
        int p0;
        @(negedge clk);
        p0 = pulses;
        repeat (4) begin @(posedge clk); @(negedge clk); end
        chk("R1 pulses in reset", pulses - p0, 4);
        chk("R1 sleep in reset", int'(sleep), 0);
        rst_n = 1'b1;
        tick(1, ADD, 0, 0);
        chk("R10 awake after reset", int'(sleep), 0);
    endtask

    task automatic t_halt;
        int p0;
        tick(1, ADD, 0, 0);
        tick(0, HALT, 0, 0);
        chk("R2 invalid halt ignored", int'(sleep), 0);
        p0 = pulses;
        tick(1, HALT, 0, 0);
        chk("R2 halt sets sleep", int'(sleep), 1);
        chk("R2 halt edge pulse passes", pulses - p0, 1);
        p0 = pulses;
        repeat (4) tick(1, HALT, 1, 0);
        chk("R10 no pulses asleep", pulses - p0, 0);
        chk("R8 sleep holds", int'(sleep), 1);
        p0 = pulses;
        tick(1, ADD, 0, 1);
        chk("R6 wake clears sleep", int'(sleep), 0);
        chk("R6 wake edge blocked", pulses - p0, 0);
        p0 = pulses;
        tick(1, ADD, 0, 0);
        chk("R6 pulse after wake", pulses - p0, 1);
    endtask

    task automatic t_prio;
        tick(1, HALT, 0, 1);
        chk("R7 wake beats halt", int'(sleep), 0);
        tick(1, HALT, 0, 0);
        chk("R7 halt next edge", int'(sleep), 1);
        tick(1, ADD, 0, 1);
        chk("R6 wake", int'(sleep), 0);
    endtask

    task automatic t_nop;
        repeat (3) tick(1, NOP, 0, 0);
        tick(1, ADD, 0, 0);
        tick(1, ADD, 0, 0);
        chk("R3 short run", int'(sleep), 0);
        repeat (4) tick(1, NOP, 0, 0);
        chk("R3 fourth nop edge", int'(sleep), 0);
        tick(1, NOP, 0, 0);
        chk("R3 run sleeps", int'(sleep), 1);
        tick(1, ADD, 0, 1);
        chk("R6 wake after nops", int'(sleep), 0);
    endtask

    task automatic t_invalid;
        repeat (2) tick(1, NOP, 0, 0);
        repeat (3) tick(0, ADD, 0, 0);
        tick(1, NOP, 0, 0);
        chk("R4 three valid nops", int'(sleep), 0);
        tick(1, NOP, 0, 0);
        chk("R4 fourth valid nop edge", int'(sleep), 0);
        tick(1, ADD, 0, 0);
        chk("R4 invalid kept run", int'(sleep), 1);
        tick(1, ADD, 0, 1);
    endtask

    task automatic t_stall;
        tick(1, ADD, 0, 0);
        tick(1, ADD, 1, 0);
        tick(1, ADD, 0, 0);
        tick(1, ADD, 0, 0);
        chk("R5 single repeat", int'(sleep), 0);
        tick(1, ADD, 1, 0);
        tick(1, ADD, 1, 0);
        chk("R5 second repeat edge", int'(sleep), 0);
        tick(1, ADD, 1, 0);
        chk("R5 stall sleeps", int'(sleep), 1);
        tick(1, ADD, 0, 0);
        tick(1, ADD, 0, 0);
        chk("R8 stays asleep", int'(sleep), 1);
    endtask

    task automatic t_reset_sleep;
        int p0;
        rst_n = 1'b0;
        #1;
        chk("R1 reset clears sleep", int'(sleep), 0);
        @(negedge clk);
        p0 = pulses;
        repeat (2) begin @(posedge clk); @(negedge clk); end
        chk("R1 pulses restored", pulses - p0, 2);
        rst_n = 1'b1;
        tick(1, ADD, 0, 0);
        chk("R10 running after reset", int'(sleep), 0);
    endtask

    initial begin
        #1 rst_n = 1'b0;
        t_reset();
        t_halt();
        t_prio();
        t_nop();
        t_invalid();
        t_stall();
        t_reset_sleep();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #50000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule